// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block screens the identifier of each received CAN frame against a programmable set of acceptance codes and masks, and decides whether the frame is to be kept. The receiver core presents the frame's identifier and its control bits (remote request, extended-format flag, substitute remote request), together with a one-cycle valid strobe, once the arbitration field has been captured. The filter answers one clock later with an accept pulse, a 3-bit index of the filter that matched, and a sticky receive-buffer-full flag for software.

The filter storage is 64 bits of acceptance code plus 64 bits of mask, organised as two banks of four bytes. A mode input selects how this storage is split: two wide filters that each compare the whole 32-bit identifier image, four medium filters that each compare the upper 16 bits, or eight narrow filters that each compare the top byte. A fourth mode shuts the filter so that nothing is accepted. When several filters match, the lowest-numbered one is reported. The identifier is first packed into a 32-bit image whose layout depends on the frame format, so a single set of comparators serves both standard and extended frames.

Top module: `can_id_filter`

## Requirements
- R1: After reset, accept_o is 0, rxf_o is 0, hit_idx_o is 0, and all acceptance and mask bytes are 0.
- R2: A mask bit of 1 makes the corresponding image bit don't-care; a mask bit of 0 requires that image bit to equal the acceptance bit.
- R3: For an extended frame (frame_ide_i=1) the image bytes, most significant first, are ID[28:21]; {ID[20:18], SRR, IDE, ID[17:15]}; ID[14:7]; {ID[6:0], RTR}.
- R4: For a standard frame (frame_ide_i=0) the image is {ID[10:3]; {ID[2:0], RTR, IDE, 3'b000}; 8'h00; 8'h00}, and ID[28:11] has no effect.
- R5: With mode_i=0 there are two filters; filter b compares all 32 image bits against acceptance bytes 4b..4b+3 (byte 4b against the image's top byte) and reports hit index b.
- R6: With mode_i=1 there are four filters; filter f compares image bits [31:16] against acceptance bytes 2f (top byte) and 2f+1, and reports hit index f.
- R7: With mode_i=2 there are eight filters; filter n compares image bits [31:24] against acceptance byte n and reports hit index n.
- R8: When more than one filter matches, hit_idx_o takes the lowest matching index.
- R9: With mode_i=3 no frame is accepted, rxf_o is not set and hit_idx_o keeps its value.
- R10: accept_o is a single-cycle pulse on the clock edge that samples frame_valid_i high with a match; without a strobe accept_o stays 0.
- R11: A strobed frame that matches no filter gives no accept pulse, leaves hit_idx_o unchanged and leaves rxf_o unchanged.
- R12: rxf_o is set by every accepted frame and held until a register write to address 16 with data bit 0 set; a write with bit 0 clear has no effect, and a set in the same cycle as a clear wins.
- R13: Register writes at addresses 0..7 load acceptance bytes 0..7 and at addresses 8..15 load mask bytes 0..7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_valid_i | input | 1 | One-cycle strobe: identifier fields are valid |
| frame_ide_i | input | 1 | Frame format: 1 extended, 0 standard |
| frame_id_i | input | 29 | Identifier; standard frames use bits [10:0] |
| frame_rtr_i | input | 1 | Remote request bit |
| frame_srr_i | input | 1 | Substitute remote request bit (extended frames) |
| mode_i | input | 2 | 0 two wide, 1 four medium, 2 eight narrow, 3 closed |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| accept_o | output | 1 | Accept pulse, one cycle after the strobe |
| rxf_o | output | 1 | Sticky receive-buffer-full flag |
| hit_idx_o | output | 3 | Index of the lowest matching filter |

## Verification
The bench builds the block with its defaults, two banks and a 5-bit register address, which gives eight byte registers per table and the full 3-bit hit index. That size reaches every index from 0 to 7, a priority contest between the two banks in the narrow mode, and a mode change over a fixed register set where the same image is rejected in one split and accepted in another. Partial masks on one byte and standard frames with junk in the unused identifier bits cover the masking and format layout.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int IMG_W = 32;

  typedef enum logic [1:0] {
    MODE_WIDE   = 2'd0,
    MODE_HALF   = 2'd1,
    MODE_BYTE   = 2'd2,
    MODE_CLOSED = 2'd3
  } filt_mode_e;
endpackage

// File: rtl/can_id_image.sv
module can_id_image import can_filt_pkg::*; (
  input  logic [28:0]      id_i,
  input  logic             ide_i,
  input  logic             rtr_i,
  input  logic             srr_i,
  output logic [IMG_W-1:0] img_o
);
  always_comb begin
    if (ide_i) begin
      img_o = {id_i[28:21], id_i[20:18], srr_i, ide_i, id_i[17:15],
               id_i[14:7], id_i[6:0], rtr_i};
    end else begin
      // standard frame: upper id bits unused
      img_o = {id_i[10:3], id_i[2:0], rtr_i, ide_i, 3'b000, 16'h0000};
    end
  end
endmodule

// File: rtl/can_filter_bank.sv
module can_filter_bank import can_filt_pkg::*; #(
  localparam int BYTES  = IMG_W / 8,
  localparam int HALVES = BYTES / 2
) (
  input  logic [IMG_W-1:0]  acc_i,
  input  logic [IMG_W-1:0]  mask_i,
  input  logic [IMG_W-1:0]  img_i,
  output logic              m_wide_o,
  output logic [HALVES-1:0] m_half_o,
  output logic [BYTES-1:0]  m_byte_o
);
  logic [BYTES-1:0] eq_w, eq_h, eq_b;

  for (genvar n = 0; n < BYTES; n++) begin : g_byte
    logic [7:0] acc_b, msk_b;
    assign acc_b = acc_i[IMG_W-1-8*n -: 8];
    assign msk_b = mask_i[IMG_W-1-8*n -: 8];
    // each split compares a different slice of the image
    assign eq_w[n] = (((img_i[IMG_W-1-8*n -: 8])       ^ acc_b) & ~msk_b) == 8'h00;
    assign eq_h[n] = (((img_i[IMG_W-1-8*(n%2) -: 8])   ^ acc_b) & ~msk_b) == 8'h00;
    assign eq_b[n] = (((img_i[IMG_W-1 -: 8])           ^ acc_b) & ~msk_b) == 8'h00;
  end

  for (genvar k = 0; k < HALVES; k++) begin : g_half
    assign m_half_o[k] = eq_h[2*k] & eq_h[2*k+1];
  end

  assign m_wide_o = &eq_w;
  assign m_byte_o = eq_b;
endmodule

// File: rtl/can_hit_prio.sv
module can_hit_prio #(
  parameter  int N     = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     hits_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |hits_i;
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter import can_filt_pkg::*; #(
  parameter  int NUM_BANKS = 2,
  parameter  int ADDR_W    = 5,
  localparam int BYTES     = IMG_W / 8,
  localparam int NUM_FILT  = NUM_BANKS * BYTES,
  localparam int IDX_W     = $clog2(NUM_FILT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_valid_i,
  input  logic              frame_ide_i,
  input  logic [28:0]       frame_id_i,
  input  logic              frame_rtr_i,
  input  logic              frame_srr_i,
  input  logic [1:0]        mode_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic              accept_o,
  output logic              rxf_o,
  output logic [IDX_W-1:0]  hit_idx_o
);
  localparam int HALVES    = BYTES / 2;
  localparam int MASK_BASE = NUM_FILT;
  localparam int CTRL_ADDR = 2 * NUM_FILT;

  logic [7:0] acc_q  [NUM_FILT];
  logic [7:0] mask_q [NUM_FILT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_FILT; i++) begin
        acc_q[i]  <= 8'h00;
        mask_q[i] <= 8'h00;
      end
    end else if (reg_we_i) begin
      for (int i = 0; i < NUM_FILT; i++) begin
        if (reg_addr_i == ADDR_W'(i))             acc_q[i]  <= reg_wdata_i;
        if (reg_addr_i == ADDR_W'(MASK_BASE + i)) mask_q[i] <= reg_wdata_i;
      end
    end
  end

  logic [IMG_W-1:0] img;

  can_id_image u_image (
    .id_i  (frame_id_i),
    .ide_i (frame_ide_i),
    .rtr_i (frame_rtr_i),
    .srr_i (frame_srr_i),
    .img_o (img)
  );

  logic [NUM_BANKS-1:0]        wide_hits;
  logic [NUM_BANKS*HALVES-1:0] half_hits;
  logic [NUM_FILT-1:0]         byte_hits;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [IMG_W-1:0] acc_flat, mask_flat;
    always_comb begin
      for (int n = 0; n < BYTES; n++) begin
        acc_flat[IMG_W-1-8*n -: 8]  = acc_q[b*BYTES+n];
        mask_flat[IMG_W-1-8*n -: 8] = mask_q[b*BYTES+n];
      end
    end
    can_filter_bank u_bank (
      .acc_i    (acc_flat),
      .mask_i   (mask_flat),
      .img_i    (img),
      .m_wide_o (wide_hits[b]),
      .m_half_o (half_hits[b*HALVES +: HALVES]),
      .m_byte_o (byte_hits[b*BYTES +: BYTES])
    );
  end

  filt_mode_e          mode;
  logic [NUM_FILT-1:0] hits;

  assign mode = filt_mode_e'(mode_i);

  always_comb begin
    hits = '0;
    case (mode)
      MODE_WIDE: hits[NUM_BANKS-1:0]        = wide_hits;
      MODE_HALF: hits[NUM_BANKS*HALVES-1:0] = half_hits;
      MODE_BYTE: hits                       = byte_hits;
      default:   hits                       = '0;
    endcase
  end

  logic             any_hit;
  logic [IDX_W-1:0] win_idx;

  can_hit_prio #(.N(NUM_FILT)) u_prio (
    .hits_i (hits),
    .any_o  (any_hit),
    .idx_o  (win_idx)
  );

  logic set_rxf, clr_rxf;
  assign set_rxf = frame_valid_i & any_hit;
  assign clr_rxf = reg_we_i & (reg_addr_i == ADDR_W'(CTRL_ADDR)) & reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o  <= 1'b0;
      rxf_o     <= 1'b0;
      hit_idx_o <= '0;
    end else begin
      accept_o <= set_rxf;
      if (set_rxf)      hit_idx_o <= win_idx;
      if (set_rxf)      rxf_o <= 1'b1;
      else if (clr_rxf) rxf_o <= 1'b0;
    end
  end

  p_accept_sets_rxf_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> rxf_o);

  p_closed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && mode == MODE_CLOSED) |=> (!accept_o && $stable(hit_idx_o)));

  p_no_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |=> !accept_o);

  p_miss_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && !any_hit) |=> (!accept_o && $stable(hit_idx_o)));

  p_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_rxf && !set_rxf) |=> !rxf_o);

  p_wide_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_rxf && mode == MODE_WIDE) |=> (hit_idx_o < IDX_W'(NUM_BANKS)));

  p_lowest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_hit |-> (hits[win_idx] && ((hits & ((NUM_FILT'(1) << win_idx) - NUM_FILT'(1))) == '0)));
endmodule

// File: tb/tb_can_id_filter.sv
`timescale 1ns/1ps
module tb_can_id_filter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_valid_i = 1'b0;
  logic        frame_ide_i = 1'b0;
  logic [28:0] frame_id_i = '0;
  logic        frame_rtr_i = 1'b0;
  logic        frame_srr_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        reg_we_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic        accept_o, rxf_o;
  logic [2:0]  hit_idx_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk_i = ~clk_i;

  can_id_filter dut (.*);

  // {mode, image, exp_accept, exp_idx}
  localparam logic [37:0] VEC [14] = '{
    {2'd0, 32'h11182218, 1'b1, 3'd0},  // R5 bank0
    {2'd0, 32'h3F184418, 1'b1, 3'd1},  // R5 bank1, R2 partial mask
    {2'd0, 32'h11182219, 1'b0, 3'd1},  // R11 rtr bit differs
    {2'd1, 32'h22180000, 1'b1, 3'd1},  // R6
    {2'd1, 32'h3A18FFFF, 1'b1, 3'd2},  // R6, R2
    {2'd1, 32'h44181234, 1'b1, 3'd3},  // R6
    {2'd1, 32'h11185555, 1'b1, 3'd0},  // R6
    {2'd2, 32'h44180000, 1'b1, 3'd6},  // R7
    {2'd2, 32'h18180000, 1'b1, 3'd1},  // R8 1,3,5,7 all match
    {2'd2, 32'h35180000, 1'b1, 3'd4},  // R7, R2
    {2'd2, 32'h99180000, 1'b0, 3'd4},  // R11
    {2'd3, 32'h11182218, 1'b0, 3'd4},  // R9
    {2'd1, 32'h11190000, 1'b0, 3'd4},  // R6 second byte differs
    {2'd2, 32'h11190000, 1'b1, 3'd0}   // R7 same image passes narrow
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  // R3 inverse: rebuild id and control bits from a wanted extended image
  task automatic load_ext(input logic [31:0] im);
    frame_ide_i = im[19];
    frame_srr_i = im[20];
    frame_rtr_i = im[0];
    frame_id_i  = {im[31:24], im[23:21], im[18:16], im[15:8], im[7:1]};
  endtask

  task automatic strobe(input logic clr);
    @(negedge clk_i);
    frame_valid_i = 1'b1;
    if (clr) begin reg_we_i = 1'b1; reg_addr_i = 5'd16; reg_wdata_i = 8'h01; end
    @(negedge clk_i);
    frame_valid_i = 1'b0;
    reg_we_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 accept", 32'(accept_o), 0);
    check("R1 rxf", 32'(rxf_o), 0);
    check("R1 idx", 32'(hit_idx_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: zero registers only match an all-zero image in mode 0
    mode_i = 2'd0; load_ext(32'h00080000);
    strobe(1'b0);
    check("R1 zero regs reject", 32'(accept_o), 0);

    // R13: acceptance at 0..7, masks at 8..15
    wr(0, 8'h11); wr(1, 8'h18); wr(2, 8'h22); wr(3, 8'h18);
    wr(4, 8'h33); wr(5, 8'h18); wr(6, 8'h44); wr(7, 8'h18);
    wr(12, 8'h0F);

    foreach (VEC[i]) begin
      wr(5'd16, 8'h01);
      mode_i = VEC[i][37:36];
      load_ext(VEC[i][35:4]);
      strobe(1'b0);
      check($sformatf("R13 vec%0d accept", i), 32'(accept_o), 32'(VEC[i][3]));
      check($sformatf("R8 vec%0d idx", i), 32'(hit_idx_o), 32'(VEC[i][2:0]));
      check($sformatf("R12 vec%0d rxf", i), 32'(rxf_o), 32'(VEC[i][3]));
    end

    // R4: standard frame in bank1 wide filter, junk in upper id bits
    wr(4, 8'h54); wr(5, 8'hB0); wr(6, 8'h00); wr(7, 8'h00); wr(12, 8'h00);
    wr(5'd16, 8'h01);
    mode_i = 2'd0;
    frame_ide_i = 1'b0; frame_srr_i = 1'b0; frame_rtr_i = 1'b1;
    frame_id_i = {18'h3FFFF, 11'h2A5};
    strobe(1'b0);
    check("R4 std accept", 32'(accept_o), 1);
    check("R4 std idx", 32'(hit_idx_o), 1);
    // R10: pulse lasts one cycle
    @(negedge clk_i);
    check("R10 pulse ends", 32'(accept_o), 0);
    frame_rtr_i = 1'b0;
    wr(5'd16, 8'h01);
    strobe(1'b0);
    check("R4 rtr mismatch", 32'(accept_o), 0);
    check("R11 rxf unchanged", 32'(rxf_o), 0);
    mode_i = 2'd2; frame_rtr_i = 1'b1;
    strobe(1'b0);
    check("R4 std narrow idx", 32'(hit_idx_o), 4);

    // R12: sticky flag behaviour
    mode_i = 2'd3;
    strobe(1'b0);
    check("R9 closed no accept", 32'(accept_o), 0);
    check("R12 sticky after miss", 32'(rxf_o), 1);
    wr(5'd16, 8'hFE);
    check("R12 bit0 clear ignored", 32'(rxf_o), 1);
    wr(5'd16, 8'h01);
    check("R12 cleared", 32'(rxf_o), 0);
    mode_i = 2'd2;
    strobe(1'b1);
    check("R12 set wins accept", 32'(accept_o), 1);
    check("R12 set wins rxf", 32'(rxf_o), 1);
    repeat (3) @(negedge clk_i);
    check("R10 no strobe", 32'(accept_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule